// File: doc/BRIEF.md
# Column Mixing Transform Unit (Forward and Inverse)

This unit applies the AES column-mixing linear transform, or its inverse, to one 32-bit state column per cycle. Both directions are computed combinationally from the same input. A mode bit picks one of them, and the choice lands in a single 32-bit output register, so the unit can sit directly at a pipeline boundary of a round datapath. A full 128-bit state uses four instances side by side.

The forward direction builds each output byte as a GF(2^8) dot product with weights 2, 3, 1, 1. It folds the doubling of two bytes into one doubling of their XOR, so the top bits of those bytes enter the reduction only through a single shared bit. The inverse direction avoids the wide weights 14, 11, 13, 9. It splits each output into a weight-15 multiple of the column's XOR sum, which is computed once and used by all four bytes, plus a residue with small weights. That residue draws on two weight-4 products, and each product is shared by two output bytes.

Top module: `mixcol_unit`

## Requirements
- R1: With `inverse` = 0, output byte i equals 2·x[i] ⊕ 3·x[i+1] ⊕ x[i+2] ⊕ x[i+3], with indices taken mod 4. Row byte i of a column occupies bits [31−8i : 24−8i], so row 0 is the most significant byte. Products are in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1.
- R2: With `inverse` = 1, output byte i equals 0E·x[i] ⊕ 0B·x[i+1] ⊕ 0D·x[i+2] ⊕ 09·x[i+3] (hex weights), with the same byte order and field as R1.
- R3: In the forward direction, the XOR of the four output bytes equals the XOR of the four input bytes.
- R4: In the inverse direction, the XOR of the four output bytes equals the XOR of the four input bytes.
- R5: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high outside reset. The result for that input appears on `col_out` at the same time.
- R6: While `in_valid` is low, `col_out` keeps its previous value and ignores changes on `col_in` and `inverse`.
- R7: Reset is synchronous and active low. A clock edge with `rst_n` low clears `out_valid` and `col_out` to zero, even if `in_valid` is high.
- R8: Passing the forward result of any column through the inverse direction gives back the original column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Column on `col_in` is to be transformed |
| inverse | input | 1 | 0 selects the forward transform, 1 selects the inverse |
| col_in | input | 32 | Input column, row 0 in the top byte |
| out_valid | output | 1 | `col_out` holds a fresh result |
| col_out | output | 32 | Registered transformed column, row 0 in the top byte |

## Verification
The hardest behaviour to reach from the ports is a carry through the reduction polynomial in the shared terms. That needs a column where the top bits of neighbouring bytes, or of the XOR sum, are set in particular combinations, and plain test vectors rarely hit all of them. The stimulus runs a table of known columns through both directions. It then feeds a long stream of pseudo-random columns through forward and then inverse, comparing each step against a behavioural matrix multiply. That stream reaches every mix of top bits many times. Directed steps then check output hold while idle and a reset that arrives together with valid input.

// File: rtl/mixcol_pkg.sv
// Shared constants and field helpers for the column mixing unit.
// Assumes the AES field: bytes reduced modulo x^8 + x^4 + x^3 + x + 1.
package mixcol_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;
    // Element 0 is the most significant byte, which is row 0 of the column.
    typedef logic [0:COL_BYTES-1][BYTE_W-1:0] col_t;

    // Doubling in the field: shift left and fold the carry back in.
    function automatic byte_t fmul2(byte_t v);
        return {v[BYTE_W-2:0], 1'b0} ^ ({BYTE_W{v[BYTE_W-1]}} & RED_POLY);
    endfunction

    // Quadrupling in the field: two doublings.
    function automatic byte_t fmul4(byte_t v);
        return fmul2(fmul2(v));
    endfunction

    // XOR of all bytes of a column.
    function automatic byte_t col_fold(col_t c);
        byte_t acc;
        acc = '0;
        for (int i = 0; i < COL_BYTES; i++) acc ^= c[i];
        return acc;
    endfunction
endpackage

// File: rtl/mc_fwd_byte.sv
// One forward output byte: p = 2*a ^ 3*b ^ c ^ d.
// Rewritten as 2*(a^b) ^ b ^ c ^ d, so a[7] and b[7] reach the reduction
// only through the shared bit x. Assumes 8-bit bytes.
module mc_fwd_byte
    import mixcol_pkg::*;
(
    input  byte_t a,
    input  byte_t b,
    input  byte_t c,
    input  byte_t d,
    output byte_t p
);
    logic  x;
    byte_t s;
    byte_t lin;
    byte_t red;

    // Build the shifted sum, the reduction pattern on x, and the plain terms.
    always_comb begin
        s   = a ^ b;
        x   = a[BYTE_W-1] ^ b[BYTE_W-1];
        red = {BYTE_W{x}} & RED_POLY;
        lin = b ^ c ^ d;
        p   = {s[BYTE_W-2:0], 1'b0} ^ red ^ lin;
    end
endmodule

// File: rtl/mc_fwd_column.sv
// Forward column transform: four byte units fed with rotated rows.
// Assumes the column row order of mixcol_pkg::col_t.
module mc_fwd_column
    import mixcol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  col_t col_i,
    output col_t col_o
);
    for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
        mc_fwd_byte u_byte (
            .a (col_i[i]),
            .b (col_i[(i + 1) % COL_BYTES]),
            .c (col_i[(i + 2) % COL_BYTES]),
            .d (col_i[(i + 3) % COL_BYTES]),
            .p (col_o[i])
        );
    end

    // The column weights sum to 1, so the byte XOR is preserved.
    assert_fwd_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_fold(col_o) == col_fold(col_i));
endmodule

// File: rtl/mc_inv_column.sv
// Inverse column transform:
//   out[i] = F*S ^ x[i] ^ 4*(x[i+1]^x[i+3]) ^ 2*(x[i+2]^x[i+3])
// S is the XOR of the column. F*S is built once. 4*(x0^x2) serves the
// odd rows and 4*(x1^x3) serves the even rows. Assumes four rows.
module mc_inv_column
    import mixcol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  col_t col_i,
    output col_t col_o
);
    byte_t sum;
    byte_t sum_x2;
    byte_t sum_x4;
    byte_t f_sum;
    byte_t q_ac;
    byte_t q_bd;

    // Column-wide shared terms.
    always_comb begin
        sum    = col_fold(col_i);
        sum_x2 = fmul2(sum);
        sum_x4 = fmul2(sum_x2);
        f_sum  = fmul2(sum_x4) ^ sum_x4 ^ sum_x2 ^ sum;
        q_ac   = fmul4(col_i[0] ^ col_i[2]);
        q_bd   = fmul4(col_i[1] ^ col_i[3]);
    end

    for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
        // Per-row residue on top of the shared weight-15 term.
        always_comb begin
            col_o[i] = f_sum ^ col_i[i]
                     ^ (((i % 2) == 1) ? q_ac : q_bd)
                     ^ fmul2(col_i[(i + 2) % COL_BYTES] ^ col_i[(i + 3) % COL_BYTES]);
        end
    end

    // Weights 0E^0B^0D^09 equal 1, so the byte XOR is preserved.
    assert_inv_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_fold(col_o) == col_fold(col_i));
endmodule

// File: rtl/mixcol_unit.sv
// Column mixing unit: forward and inverse transforms side by side, a mode
// mux, and one output register with a valid bit one cycle behind the input.
// Assumes a synchronous active-low reset. Output holds while idle.
module mixcol_unit
    import mixcol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             inverse,
    input  logic [COL_W-1:0] col_in,
    output logic             out_valid,
    output logic [COL_W-1:0] col_out
);
    col_t col_w;
    col_t fwd_w;
    col_t inv_w;
    col_t sel_w;

    assign col_w = col_t'(col_in);

    mc_fwd_column u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .col_i (col_w),
        .col_o (fwd_w)
    );

    mc_inv_column u_inv (
        .clk   (clk),
        .rst_n (rst_n),
        .col_i (col_w),
        .col_o (inv_w)
    );

    // Mode select ahead of the single output register.
    always_comb sel_w = inverse ? inv_w : fwd_w;

    // Output register with load enable, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            col_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) col_out <= COL_W'(sel_w);
        end
    end

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col_out));
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && col_out == '0));
endmodule

// File: tb/tb_mixcol_unit.sv
// Self-checking bench: known-column table, pseudo-random round trips,
// then directed hold and reset cases.
module tb_mixcol_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam int NRAND = 300;

    // Table entries: {mode, input column, expected column}.
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 32'hdb135345, 32'h8e4da1bc},
        {1'b0, 32'hf20a225c, 32'h9fdc589d},
        {1'b0, 32'hc6c6c6c6, 32'hc6c6c6c6},
        {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6},
        {1'b0, 32'h2d26314c, 32'h4d7ebdf8},
        {1'b0, 32'h01010101, 32'h01010101},
        {1'b1, 32'h8e4da1bc, 32'hdb135345},
        {1'b1, 32'h9fdc589d, 32'hf20a225c},
        {1'b1, 32'hc6c6c6c6, 32'hc6c6c6c6},
        {1'b1, 32'hd5d5d7d6, 32'hd4d4d4d5},
        {1'b1, 32'h4d7ebdf8, 32'h2d26314c},
        {1'b1, 32'h01010101, 32'h01010101}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        inverse = 1'b0;
    logic [31:0] col_in = '0;
    logic        out_valid;
    logic [31:0] col_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixcol_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .inverse   (inverse),
        .col_in    (col_in),
        .out_valid (out_valid),
        .col_out   (col_out)
    );

    // Shift-and-add field multiply.
    function automatic logic [7:0] gm(logic [7:0] k, logic [7:0] v);
        logic [7:0] acc = '0;
        logic [7:0] t = v;
        for (int i = 0; i < 8; i++) begin
            if (k[i]) acc ^= t;
            t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
        end
        return acc;
    endfunction

    // Matrix model: circulant first row 2 3 1 1 or 0E 0B 0D 09.
    function automatic logic [31:0] model(logic inv, logic [31:0] c);
        logic [7:0] x [4];
        logic [7:0] w [4];
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) x[i] = c[31-8*i -: 8];
        if (inv) w = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        else     w = '{8'h02, 8'h03, 8'h01, 8'h01};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] o = '0;
            for (int k = 0; k < 4; k++) o ^= gm(w[k], x[(i+k)%4]);
            r[31-8*i -: 8] = o;
        end
        return r;
    endfunction

    function automatic logic [7:0] fold(logic [31:0] c);
        return c[31:24] ^ c[23:16] ^ c[15:8] ^ c[7:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one column for one cycle; return after the registered result is visible.
    task automatic apply(logic mode, logic [31:0] c);
        @(negedge clk);
        col_in = c; inverse = mode; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1234_5678;
        logic [31:0] fwd;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        check("R7 reset valid", {31'b0, out_valid}, 32'd0);
        check("R7 reset data", col_out, 32'd0);
        rst_n = 1'b1;

        for (int n = 0; n < NVEC; n++) begin
            apply(VEC[n][64], VEC[n][63:32]);
            check("R5 valid", {31'b0, out_valid}, 32'd1);
            check(VEC[n][64] ? "R2 table" : "R1 table", col_out, VEC[n][31:0]);
            check(VEC[n][64] ? "R2 model" : "R1 model", col_out, model(VEC[n][64], VEC[n][63:32]));
        end

        for (int n = 0; n < NRAND; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} ^ (n * 32'h9E37_79B9);
            apply(1'b0, lfsr);
            fwd = col_out;
            check("R1 random", fwd, model(1'b0, lfsr));
            check("R3 fold", {24'b0, fold(fwd)}, {24'b0, fold(lfsr)});
            apply(1'b1, fwd);
            check("R2 random", col_out, model(1'b1, fwd));
            check("R4 fold", {24'b0, fold(col_out)}, {24'b0, fold(fwd)});
            check("R8 round trip", col_out, lfsr);
        end

        // R6: idle cycles with changing inputs leave the output alone.
        apply(1'b0, 32'hdb135345);
        held = col_out;
        @(negedge clk);
        col_in = 32'hffff_ffff; inverse = 1'b1;
        @(negedge clk);
        check("R5 idle valid", {31'b0, out_valid}, 32'd0);
        check("R6 hold", col_out, held);
        col_in = 32'h8080_8080; inverse = 1'b0;
        @(negedge clk);
        check("R6 hold again", col_out, held);

        // R7: reset wins over a valid input at the same edge.
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; col_in = 32'h1111_2222;
        @(negedge clk);
        check("R7 reset over valid", col_out, 32'd0);
        check("R7 reset valid low", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        apply(1'b1, 32'h8e4da1bc);
        check("R2 after reset", col_out, 32'hdb135345);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule